// File: doc/BRIEF.md
# Indirect Data Address Walker

This block generates the memory traffic for one channel data stream whose buffer is described by an indirect list: a table in memory whose entries each point into a data block. Software first loads the walker with the table's base address, the entry format (4-byte or 8-byte entries) and a flag that forces 2 KB blocks. The walker then serves transfer requests one at a time. Each request gives a byte length and an operation: read, write or skip.

For each request the walker splits the transfer into commands that never cross a data block boundary. It fetches a table entry only when it needs a new block, and it keeps no prefetched entries. The only entry that may start in the middle of a block is the first one. Read and write requests produce data-port commands (address, length, direction). A skip request moves the address and the byte count forward without touching data memory.

Several conditions raise a program-check error: a fault on either memory port, a misaligned entry address, a bad 4-byte pointer, or a later entry that does not start on a block boundary. The error ends the request and sets a sticky broken flag. The stream stays broken until the walker is loaded again.

Top module: `idaw_walker`

## Requirements
- R1: The block size is 4096 bytes when 8-byte entries are selected and the 2K flag is clear. In every other case it is 2048 bytes.
- R2: Entry N is read from base + 8·N in 8-byte format and from base + 4·N in 4-byte format. The response word carries the first memory byte in bits [63:56] (big-endian). A 4-byte entry occupies bits [63:32].
- R3: If the next entry address is not aligned to the entry size, the request ends with an error and no entry read is issued.
- R4: In 4-byte format, a fetched pointer with bit 31 set ends the request with an error.
- R5: The first entry after a load may point anywhere in a block. Any later entry whose pointer is not block-aligned ends the request with an error.
- R6: Each data command has length min(remaining bytes, bytes left in the block), where bytes left = block size − (address mod block size). No command crosses a block boundary.
- R6 (continued): A request that starts exactly on a block boundary, and every continuation, fetches the next entry before any data command is issued.
- R7: The operation code selects the behaviour: 0 = read (cmd_write low), 1 = write (cmd_write high), 2 or 3 = skip. A skip advances cur_addr and byte_cnt but issues no data command.
- R8: An error response on the entry port or on the data port ends the request with an error.
- R9: ent_idx increments once for every entry fetch attempt, including attempts that fail. It never steps by more than one per cycle.
- R10: Any error sets stream_broken. While stream_broken is set, a request completes at once with an error and causes no memory traffic. A load clears the flag and resets ent_idx, cur_addr and byte_cnt to zero.
- R11: req_ready is high only while the walker is idle and no load is offered. Every accepted request produces exactly one single-cycle done pulse, and done_err is high only together with done. A zero-length request completes without error and without traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_valid | input | 1 | Load a new list (taken when idle) |
| init_base | input | AW | List base address |
| init_fmt64 | input | 1 | 1 = 8-byte entries, 0 = 4-byte entries |
| init_half | input | 1 | Force 2 KB blocks |
| req_valid | input | 1 | Transfer request offered |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_len | input | LW | Request length in bytes |
| req_op | input | 2 | 0 read, 1 write, 2/3 skip |
| done | output | 1 | Request finished (one cycle) |
| done_err | output | 1 | Request ended with a program check |
| ent_req_valid | output | 1 | Entry read request |
| ent_req_ready | input | 1 | Entry port accepts request |
| ent_addr | output | AW | Entry address |
| ent_rsp_valid | input | 1 | Entry response |
| ent_rsp_data | input | 64 | Entry bytes, first byte in [63:56] |
| ent_rsp_err | input | 1 | Entry read fault |
| cmd_valid | output | 1 | Data command valid |
| cmd_ready | input | 1 | Data port accepts command |
| cmd_addr | output | AW | Data command address |
| cmd_len | output | LW | Data command length |
| cmd_write | output | 1 | Command direction, 1 = write |
| dat_rsp_valid | input | 1 | Data command completed |
| dat_rsp_err | input | 1 | Data access fault |
| ent_idx | output | IW | Index of next entry to fetch |
| cur_addr | output | AW | Current data address |
| byte_cnt | output | CW | Bytes transferred since load |
| stream_broken | output | 1 | Sticky error flag |

## Verification
Some properties are checked on every cycle by the assertions:
- every data command stays inside one block and holds steady while it is stalled;
- every issued entry address is aligned to the entry size;
- the entry index moves by at most one per cycle;
- the broken flag is released only by a load;
- done_err never appears without done, and done lasts a single cycle.

Other behaviour only the bench scenarios can show:
- the exact order in which entries and commands are issued;
- the deferred fetch at a block boundary;
- the mid-block first entry;
- the rejection of a misaligned later entry or of a 4-byte pointer with bit 31 set;
- the final address and count after a skip.

// File: rtl/idaw_pkg.sv
package idaw_pkg;
   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_SKIP  = 2'd2,
      OP_SKIP3 = 2'd3
   } idaw_op_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_FREQ,
      S_FWAIT,
      S_CHUNK,
      S_CREQ,
      S_CWAIT
   } idaw_st_e;

   localparam int unsigned BLK_SMALL = 2048;
   localparam int unsigned BLK_LARGE = 4096;
endpackage

// File: rtl/idaw_blk_calc.sv
module idaw_blk_calc #(
   parameter int unsigned LW         = 16,
   parameter bit          BIG_BLK_EN = 1'b1
) (
   input  logic          fmt64,
   input  logic          half,
   input  logic [11:0]   addr_lo,
   input  logic [LW-1:0] rem,
   output logic [12:0]   blk_size,
   output logic [11:0]   blk_mask,
   output logic [12:0]   left,
   output logic [LW-1:0] chunk
);
   logic          big;
   logic [LW:0]   left_x;
   logic [LW:0]   rem_x;

   generate
      if (LW < 13) begin : g_bad_lw
         $error("idaw_blk_calc: LW must be at least 13");
      end
      if (BIG_BLK_EN) begin : g_big
         assign big = fmt64 & ~half;
      end else begin : g_small_only
         assign big = 1'b0;
      end
   endgenerate

   assign blk_size = big ? 13'(idaw_pkg::BLK_LARGE) : 13'(idaw_pkg::BLK_SMALL);
   assign blk_mask = 12'(blk_size - 13'd1);
   assign left     = blk_size - {1'b0, addr_lo & blk_mask};
   assign left_x   = {{(LW-12){1'b0}}, left};
   assign rem_x    = {1'b0, rem};
   assign chunk    = (rem_x < left_x) ? rem : left_x[LW-1:0];
endmodule

// File: rtl/idaw_ptr_check.sv
module idaw_ptr_check #(
   parameter int unsigned AW = 64,
   parameter int unsigned IW = 16
) (
   input  logic [AW-1:0] base,
   input  logic [IW-1:0] idx,
   input  logic          fmt64,
   input  logic [63:0]   rsp_data,
   input  logic [11:0]   blk_mask,
   output logic [AW-1:0] ent_addr,
   output logic          addr_ok,
   output logic [AW-1:0] ptr,
   output logic          ptr_bad,
   output logic          ptr_unaligned
);
   logic [AW-1:0] idx_x;
   logic [AW-1:0] p64;
   logic [AW-1:0] p32;

   generate
      if (AW < 32 || AW > 64) begin : g_bad_aw
         $error("idaw_ptr_check: AW must be within 32..64");
      end
      if (IW >= AW) begin : g_bad_iw
         $error("idaw_ptr_check: IW must be below AW");
      end
      if (AW == 64) begin : g_p64_full
         assign p64 = rsp_data;
      end else begin : g_p64_cut
         assign p64 = rsp_data[AW-1:0];
      end
      if (AW > 32) begin : g_p32_ext
         assign p32 = {{(AW-32){1'b0}}, rsp_data[63:32]};
      end else begin : g_p32_eq
         assign p32 = rsp_data[63:32];
      end
   endgenerate

   assign idx_x         = {{(AW-IW){1'b0}}, idx};
   assign ent_addr      = base + (fmt64 ? (idx_x << 3) : (idx_x << 2));
   assign addr_ok       = fmt64 ? (ent_addr[2:0] == 3'd0) : (ent_addr[1:0] == 2'd0);
   assign ptr           = fmt64 ? p64 : p32;
   assign ptr_bad       = ~fmt64 & rsp_data[63];
   assign ptr_unaligned = |(ptr[11:0] & blk_mask);
endmodule

// File: rtl/idaw_walker.sv
module idaw_walker #(
   parameter int unsigned AW         = 64,
   parameter int unsigned LW         = 16,
   parameter int unsigned IW         = 16,
   parameter int unsigned CW         = 32,
   parameter bit          BIG_BLK_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init_valid,
   input  logic [AW-1:0] init_base,
   input  logic          init_fmt64,
   input  logic          init_half,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [LW-1:0] req_len,
   input  logic [1:0]    req_op,
   output logic          done,
   output logic          done_err,
   output logic          ent_req_valid,
   input  logic          ent_req_ready,
   output logic [AW-1:0] ent_addr,
   input  logic          ent_rsp_valid,
   input  logic [63:0]   ent_rsp_data,
   input  logic          ent_rsp_err,
   output logic          cmd_valid,
   input  logic          cmd_ready,
   output logic [AW-1:0] cmd_addr,
   output logic [LW-1:0] cmd_len,
   output logic          cmd_write,
   input  logic          dat_rsp_valid,
   input  logic          dat_rsp_err,
   output logic [IW-1:0] ent_idx,
   output logic [AW-1:0] cur_addr,
   output logic [CW-1:0] byte_cnt,
   output logic          stream_broken
);
   import idaw_pkg::*;

   generate
      if (CW < LW) begin : g_bad_cw
         $error("idaw_walker: CW must be at least LW");
      end
   endgenerate

   idaw_st_e      st;
   idaw_op_e      op;
   logic [AW-1:0] base;
   logic          fmt64, half, first;
   logic [LW-1:0] rem;

   logic [12:0]   blk_size, left;
   logic [11:0]   blk_mask;
   logic [LW-1:0] chunk;
   logic          addr_ok, ptr_bad, ptr_unal;
   logic [AW-1:0] ptr;

   logic          init_fire, is_skip, fail_now, adv_now;

   idaw_blk_calc #(.LW(LW), .BIG_BLK_EN(BIG_BLK_EN)) u_calc (
      .fmt64(fmt64), .half(half), .addr_lo(cur_addr[11:0]), .rem(rem),
      .blk_size(blk_size), .blk_mask(blk_mask), .left(left), .chunk(chunk)
   );

   idaw_ptr_check #(.AW(AW), .IW(IW)) u_ptr (
      .base(base), .idx(ent_idx), .fmt64(fmt64), .rsp_data(ent_rsp_data),
      .blk_mask(blk_mask), .ent_addr(ent_addr), .addr_ok(addr_ok),
      .ptr(ptr), .ptr_bad(ptr_bad), .ptr_unaligned(ptr_unal)
   );

   assign init_fire     = (st == S_IDLE) && init_valid;
   assign req_ready     = (st == S_IDLE) && !init_valid;
   assign is_skip       = op[1];
   assign ent_req_valid = (st == S_FREQ) && addr_ok;
   assign cmd_valid     = (st == S_CREQ);
   assign cmd_addr      = cur_addr;
   assign cmd_len       = chunk;
   assign cmd_write     = (op == OP_WRITE);

   always_comb begin
      fail_now = 1'b0;
      adv_now  = 1'b0;
      unique case (st)
         S_FREQ:  fail_now = !addr_ok;
         S_FWAIT: fail_now = ent_rsp_valid &&
                             (ent_rsp_err || ptr_bad || (!first && ptr_unal));
         S_CHUNK: adv_now  = is_skip;
         S_CWAIT: begin
            fail_now = dat_rsp_valid && dat_rsp_err;
            adv_now  = dat_rsp_valid && !dat_rsp_err;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st            <= S_IDLE;
         op            <= OP_READ;
         base          <= '0;
         fmt64         <= 1'b0;
         half          <= 1'b0;
         first         <= 1'b0;
         rem           <= '0;
         ent_idx       <= '0;
         cur_addr      <= '0;
         byte_cnt      <= '0;
         stream_broken <= 1'b0;
         done          <= 1'b0;
         done_err      <= 1'b0;
      end else begin
         done     <= 1'b0;
         done_err <= 1'b0;
         if (init_fire) begin
            base          <= init_base;
            fmt64         <= init_fmt64;
            half          <= init_half;
            ent_idx       <= '0;
            cur_addr      <= '0;
            byte_cnt      <= '0;
            stream_broken <= 1'b0;
         end else if (st == S_IDLE && req_valid) begin
            op  <= idaw_op_e'(req_op);
            rem <= req_len;
            if (stream_broken) begin
               done     <= 1'b1;
               done_err <= 1'b1;
            end else if (req_len == '0) begin
               done <= 1'b1;
            end else if (ent_idx == '0) begin
               first <= 1'b1;
               st    <= S_FREQ;
            end else if (left == blk_size) begin
               first <= 1'b0;
               st    <= S_FREQ;
            end else begin
               st <= S_CHUNK;
            end
         end
         if (st == S_FREQ && !addr_ok) ent_idx <= ent_idx + 1'b1;
         if (st == S_FREQ && addr_ok && ent_req_ready) st <= S_FWAIT;
         if (st == S_FWAIT && ent_rsp_valid) begin
            ent_idx <= ent_idx + 1'b1;
            if (!fail_now) begin
               cur_addr <= ptr;
               st       <= S_CHUNK;
            end
         end
         if (st == S_CHUNK && !is_skip) st <= S_CREQ;
         if (st == S_CREQ && cmd_ready) st <= S_CWAIT;
         if (adv_now) begin
            cur_addr <= cur_addr + AW'(chunk);
            byte_cnt <= byte_cnt + CW'(chunk);
            rem      <= rem - chunk;
            if (rem == chunk) begin
               done <= 1'b1;
               st   <= S_IDLE;
            end else begin
               first <= 1'b0;
               st    <= S_FREQ;
            end
         end
         if (fail_now) begin
            stream_broken <= 1'b1;
            done          <= 1'b1;
            done_err      <= 1'b1;
            st            <= S_IDLE;
         end
      end
   end

   // R11
   done_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_err |-> done);
   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !init_fire |=> (ent_idx == $past(ent_idx) || ent_idx == $past(ent_idx) + 1'b1));
   // R10
   broken_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stream_broken && !init_fire) |=> stream_broken);
   // R6
   cmd_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_len != '0 &&
         (32'(cmd_addr[11:0] & blk_mask) + 32'(cmd_len)) <= 32'(blk_size)));
   // R6
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_len)));
   // R3
   ent_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ent_req_valid |-> (fmt64 ? (ent_addr[2:0] == 3'd0) : (ent_addr[1:0] == 2'd0)));
   // R7
   skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> !is_skip);
endmodule

// File: tb/tb_idaw_walker.sv
module tb_idaw_walker;
   localparam int AW = 64, LW = 16, IW = 16, CW = 32;

   logic clk = 1'b0, rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          init_valid = 0, init_fmt64 = 0, init_half = 0;
   logic [AW-1:0] init_base = '0;
   logic          req_valid = 0, req_ready;
   logic [LW-1:0] req_len = '0;
   logic [1:0]    req_op = '0;
   logic          done, done_err;
   logic          ent_req_valid, ent_rsp_valid = 0, ent_rsp_err = 0;
   logic          ent_req_ready = 1'b1;
   logic [AW-1:0] ent_addr;
   logic [63:0]   ent_rsp_data = '0;
   logic          cmd_valid, cmd_write, dat_rsp_valid = 0, dat_rsp_err = 0;
   logic          cmd_ready = 1'b1;
   logic [AW-1:0] cmd_addr, cur_addr;
   logic [LW-1:0] cmd_len;
   logic [IW-1:0] ent_idx;
   logic [CW-1:0] byte_cnt;
   logic          stream_broken;

   idaw_walker dut (.*);

   int n_chk = 0, n_bad = 0;
   logic [63:0] ent_tab [0:31];
   int          bad_ent = -1;
   logic        bad_d_en = 0;
   logic [63:0] bad_daddr = '0;

   logic [63:0] m_base, m_addr;
   logic        m_fmt, m_half, m_broken;
   int          m_idx;
   logic [31:0] m_cnt;
   logic [63:0] exp_ea[$], exp_ca[$], got_ea[$], got_ca[$];
   int          exp_cl[$], got_cl[$];
   logic        exp_cw[$], got_cw[$];

   // entry memory and data memory responders
   always @(posedge clk) begin
      int i;
      ent_rsp_valid <= 1'b0;
      dat_rsp_valid <= 1'b0;
      if (ent_req_valid) begin
         i = int'(((ent_addr - m_base) >> (m_fmt ? 3 : 2)) & 64'd31);
         got_ea.push_back(ent_addr);
         ent_rsp_valid <= 1'b1;
         ent_rsp_err   <= (i == bad_ent);
         ent_rsp_data  <= m_fmt ? ent_tab[i] : {ent_tab[i][31:0], 32'h0};
      end
      if (cmd_valid) begin
         got_ca.push_back(cmd_addr);
         got_cl.push_back(int'(cmd_len));
         got_cw.push_back(cmd_write);
         dat_rsp_valid <= 1'b1;
         dat_rsp_err   <= bad_d_en && (cmd_addr == bad_daddr);
      end
   end

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   function automatic int bsz();
      return (m_fmt && !m_half) ? 4096 : 2048;
   endfunction

   // model of one entry fetch; returns 1 on error
   function automatic bit m_fetch(input bit first);
      logic [63:0] ea, p;
      int i;
      ea = m_base + 64'(m_idx) * (m_fmt ? 64'd8 : 64'd4);
      i  = m_idx & 31;
      m_idx++;
      if (m_fmt ? (ea[2:0] != 0) : (ea[1:0] != 0)) return 1'b1;
      exp_ea.push_back(ea);
      if (i == bad_ent) return 1'b1;
      p = m_fmt ? ent_tab[i] : {32'h0, ent_tab[i][31:0]};
      if (!m_fmt && p[31]) return 1'b1;
      if (!first && (p & 64'(bsz() - 1)) != 0) return 1'b1;
      m_addr = p;
      return 1'b0;
   endfunction

   function automatic bit model_req(input int len, input int op);
      bit need, first;
      int left, ch;
      if (m_broken) return 1'b1;
      if (len == 0) return 1'b0;
      first = (m_idx == 0);
      left  = bsz() - int'(m_addr & 64'(bsz() - 1));
      need  = first || (left == bsz());
      forever begin
         if (need) begin
            if (m_fetch(first)) begin m_broken = 1'b1; return 1'b1; end
         end
         left = bsz() - int'(m_addr & 64'(bsz() - 1));
         ch   = (len < left) ? len : left;
         if (op < 2) begin
            exp_ca.push_back(m_addr); exp_cl.push_back(ch); exp_cw.push_back(op == 1);
            if (bad_d_en && m_addr == bad_daddr) begin m_broken = 1'b1; return 1'b1; end
         end
         m_addr += 64'(ch); m_cnt += 32'(ch); len -= ch;
         if (len == 0) return 1'b0;
         need = 1'b1; first = 1'b0;
      end
   endfunction

   task automatic do_init(input logic [63:0] b, input bit f, input bit h);
      @(negedge clk);
      init_valid = 1; init_base = b; init_fmt64 = f; init_half = h;
      @(negedge clk);
      init_valid = 0;
      m_base = b; m_fmt = f; m_half = h; m_idx = 0; m_addr = 0; m_cnt = 0; m_broken = 0;
   endtask

   task automatic do_req(input int len, input int op, input string rq);
      bit ee;
      int t = 0;
      exp_ea.delete(); exp_ca.delete(); exp_cl.delete(); exp_cw.delete();
      got_ea.delete(); got_ca.delete(); got_cl.delete(); got_cw.delete();
      ee = model_req(len, op);
      @(negedge clk);
      chk(req_ready, "R11", "req_ready idle", 64'(req_ready), 64'd1);
      req_valid = 1; req_len = LW'(len); req_op = 2'(op);
      @(negedge clk);
      req_valid = 0;
      while (!done && t < 20000) begin @(negedge clk); t++; end
      chk(done, rq, "done seen", 64'(done), 64'd1);
      chk(done_err == ee, rq, "done_err", 64'(done_err), 64'(ee));
      chk(got_ea.size() == exp_ea.size(), rq, "entry fetch count",
          64'(got_ea.size()), 64'(exp_ea.size()));
      foreach (exp_ea[k]) if (k < got_ea.size())
         chk(got_ea[k] == exp_ea[k], rq, "entry addr", got_ea[k], exp_ea[k]);
      chk(got_ca.size() == exp_ca.size(), rq, "cmd count",
          64'(got_ca.size()), 64'(exp_ca.size()));
      foreach (exp_ca[k]) if (k < got_ca.size()) begin
         chk(got_ca[k] == exp_ca[k], rq, "cmd addr", got_ca[k], exp_ca[k]);
         chk(got_cl[k] == exp_cl[k], rq, "cmd len", 64'(got_cl[k]), 64'(exp_cl[k]));
         chk(got_cw[k] == exp_cw[k], rq, "cmd write", 64'(got_cw[k]), 64'(exp_cw[k]));
      end
      chk(ent_idx == IW'(m_idx), "R9", "ent_idx", 64'(ent_idx), 64'(m_idx));
      chk(cur_addr == m_addr, rq, "cur_addr", cur_addr, m_addr);
      chk(byte_cnt == m_cnt, rq, "byte_cnt", 64'(byte_cnt), 64'(m_cnt));
      chk(stream_broken == m_broken, "R10", "stream_broken",
          64'(stream_broken), 64'(m_broken));
      @(negedge clk);
      chk(!done, "R11", "done single cycle", 64'(done), 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      foreach (ent_tab[k]) ent_tab[k] = '0;
      m_base = 0; m_fmt = 0; m_half = 0; m_idx = 0; m_addr = 0; m_cnt = 0; m_broken = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state, R11
      chk(req_ready && !done && !cmd_valid && !ent_req_valid && ent_idx == 0 && !stream_broken,
          "R11", "reset state", 64'(ent_idx), 64'd0);

      // 8-byte entries, 4K blocks: mid-block start, split, skip to boundary
      ent_tab[0] = 64'h0000_0001_1000_0F00;
      ent_tab[1] = 64'h0000_0002_2000_0000;
      ent_tab[2] = 64'h0000_0003_3000_0000;
      do_init(64'h8000, 1, 0);
      do_req(100, 0, "R5");
      do_req(300, 1, "R6");
      do_req(4096 - 144, 2, "R7");
      do_req(10, 0, "R6");
      do_req(0, 0, "R11");

      // 2K flag with 8-byte entries: R1
      ent_tab[0] = 64'h0000_0000_0400_0000;
      ent_tab[1] = 64'h0000_0000_0500_0800;
      do_init(64'h100, 1, 1);
      do_req(3000, 0, "R1");

      // 4-byte entries: 2K blocks even with flag clear, 4-byte spacing (R1, R2)
      ent_tab[0] = 64'h0000_0000_0012_3400;
      ent_tab[1] = 64'h0000_0000_0020_0000;
      ent_tab[2] = 64'h0000_0000_0030_0800;
      do_init(64'h204, 0, 0);
      do_req(5000, 1, "R2");

      // 4-byte pointer with bit 31 set (R4), then broken stream (R10)
      ent_tab[0] = 64'h0000_0000_8000_1000;
      do_init(64'h400, 0, 0);
      do_req(16, 0, "R4");
      do_req(16, 0, "R10");
      ent_tab[0] = 64'h0000_0000_0000_1000;
      do_init(64'h400, 0, 0);
      do_req(16, 0, "R10");

      // later entry not block-aligned (R5)
      ent_tab[0] = 64'h0000_0000_0001_0F00;
      ent_tab[1] = 64'h0000_0000_0002_0010;
      do_init(64'h0, 1, 0);
      do_req(512, 0, "R5");

      // misaligned entry address (R3)
      do_init(64'h6, 1, 0);
      do_req(8, 0, "R3");

      // entry fetch error (R8)
      ent_tab[0] = 64'h0000_0000_0001_0000;
      ent_tab[1] = 64'h0000_0000_0002_0000;
      do_init(64'h0, 1, 0);
      bad_ent = 1;
      do_req(5000, 0, "R8");
      bad_ent = -1;
      // data access error (R8)
      do_init(64'h0, 1, 0);
      bad_d_en = 1; bad_daddr = 64'h2_0000;
      do_req(5000, 1, "R8");
      bad_d_en = 0;

      // random lists and requests
      for (int s = 0; s < 12; s++) begin
         bit f, h;
         f = $urandom_range(0, 1) == 1;
         h = $urandom_range(0, 1) == 1;
         for (int k = 0; k < 32; k++) begin
            logic [63:0] r;
            r = {$urandom(), $urandom()};
            if (!f) r = {32'h0, 1'b0, r[30:0]};
            if (k > 0) r = r & ~64'hFFF;
            if ($urandom_range(0, 40) == 0) r[31] = 1'b1;
            ent_tab[k] = r;
         end
         do_init(64'(($urandom_range(0, 255)) * 8), f, h);
         for (int q = 0; q < 6; q++)
            do_req($urandom_range(1, 5000), $urandom_range(0, 3), "R6");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule